// File: doc/BRIEF.md
# Descriptor Ring Producer with Wrap Stamping

This block takes fixed-size descriptors of eight 32-bit words from an upstream source and stores each one into the next free slot of a circular ring in memory. Every stored descriptor goes out as eight single-word writes. After the last word of a slot is written, the block moves its head index forward and raises a one-cycle interrupt. The ring holds a power-of-two number of slots. Its base address, its size and an 8-bit ring identifier come from configuration inputs. The consumer reports its read position on a tail index input.

As each descriptor is stored, the producer overwrites the upper half of its final word. That half receives the ring identifier, a reserved nibble of zeros, and a 4-bit pass counter. The counter rises each time the head index wraps to slot 0. A consumer can therefore tell freshly written slots from stale ones by comparing one bit of that counter with the value it expects for the current pass, without ever fetching the head index. When storing one more slot would make the head equal to the tail, the block holds off its input so that unread slots are never overwritten.

Top module: `desc_ring_writer`

## Requirements
- R1: After reset the head index is 0, the interrupt is low, no memory write is issued, and the input is ready to accept while the tail index is 0.
- R2: An accepted descriptor is written as eight consecutive single-cycle writes, starting in the cycle after acceptance, in word order 0 to 7. Word k of slot s goes to byte address base + 32*s + 4*k, and the five low bits of the base are taken as zero.
- R3: Words 0 to 6 and bits [15:0] of word 7 are written exactly as received. Input word k sits at bits [32k+31:32k] of the descriptor bus.
- R4: Bits [27:20] of word 7 carry the configured ring identifier, and bits [19:16] of word 7 are written as zero, whatever the input held there.
- R5: Bits [31:28] of word 7 carry the pass value. It is 1 for slots written before the first wrap and goes up by one after every wrap of the head to slot 0. After 15 it continues at 0.
- R6: The head index keeps its old value until the eighth word has been written. It takes its new value in the following cycle, and the interrupt is high in that cycle only.
- R7: The input is not ready while the words of an entry are being written.
- R8: When (head + 1) mod size equals the tail index, the input is not ready, and no write takes place and the head does not move until the tail changes.
- R9: The ring holds 2^L slots, where L is the configured size exponent (1 to the maximum). The head steps from slot 2^L - 1 back to slot 0.
- R10: Two successive writes into the same slot on consecutive passes differ in bit 28 of word 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor can be taken this cycle |
| in_desc | input | 256 | Descriptor, word k at bits [32k+31:32k] |
| cfg_base | input | ADDR_W | Ring byte base address (32-byte aligned) |
| cfg_log2_size | input | LG_W | Size exponent L, ring holds 2^L slots |
| cfg_ring_id | input | 8 | Identifier stamped into every entry |
| tail_idx | input | IDX_W | Consumer read slot index |
| mem_wr_en | output | 1 | Memory word write strobe |
| mem_wr_addr | output | ADDR_W | Byte address of the word write |
| mem_wr_data | output | 32 | Word written |
| head_idx | output | IDX_W | Next slot the producer will fill |
| irq_pulse | output | 1 | One-cycle pulse per completed entry |

## Verification
The main function is tried with descriptor contents that are all zeros, all ones, alternating patterns and scattered bits. Each carries ones in the upper half of its last word, so the stamp can be told apart from data that merely passed through. A four-slot ring filled across two passes separates the first pass value from the value after one wrap. A two-slot ring driven through sixteen passes exposes the 15-to-0 rollover and the single-bit alternation a polling consumer relies on. A held tail drives the ring to full, which checks that back-pressure suppresses writes and freezes the head until the tail moves.

// File: rtl/ring_wr_pkg.sv
package ring_wr_pkg;
    localparam int DWORD_W      = 32;
    localparam int ENTRY_DWORDS = 8;
    localparam int CNT_W        = $clog2(ENTRY_DWORDS);
    localparam int SLOT_SHIFT   = $clog2(ENTRY_DWORDS * DWORD_W / 8);
    localparam int DESC_W       = ENTRY_DWORDS * DWORD_W;

    // stamp fields inside the final word of each entry
    localparam int LOOP_LSB = 28;
    localparam int LOOP_W   = 4;
    localparam int ID_LSB   = 20;
    localparam int ID_W     = 8;
    localparam int RSV_LSB  = 16;
    localparam int RSV_W    = 4;

    typedef logic [DWORD_W-1:0] dword_t;
endpackage

// File: rtl/ring_head_ctrl.sv
module ring_head_ctrl
    import ring_wr_pkg::*;
#(
    parameter int MAX_LOG2 = 6,
    parameter int IDX_W    = MAX_LOG2,
    parameter int LG_W     = $clog2(MAX_LOG2 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LG_W-1:0]   cfg_log2_size,
    input  logic [IDX_W-1:0]  tail_idx,
    input  logic              advance,
    output logic [IDX_W-1:0]  head_idx,
    output logic [LOOP_W-1:0] stamp_loop,
    output logic              full
);
    typedef struct packed {
        logic [IDX_W-1:0]  head;
        logic [LOOP_W-1:0] wraps;
    } hd_state_t;

    hd_state_t        st_d, st_q;
    logic [LG_W-1:0]  lg_eff;
    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] next_head;

    always_comb begin
        // out-of-range exponents are pulled into the legal window
        if (cfg_log2_size == '0)
            lg_eff = LG_W'(1);
        else if (int'(cfg_log2_size) > MAX_LOG2)
            lg_eff = LG_W'(MAX_LOG2);
        else
            lg_eff = cfg_log2_size;

        for (int i = 0; i < IDX_W; i++)
            mask[i] = (i < int'(lg_eff));

        next_head = (st_q.head + 1'b1) & mask;
        full      = (next_head == (tail_idx & mask));

        st_d = st_q;
        if (advance) begin
            st_d.head = next_head;
            if (next_head == '0)
                st_d.wraps = st_q.wraps + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_idx   = st_q.head;
    assign stamp_loop = st_q.wraps + 1'b1;
endmodule

// File: rtl/entry_sequencer.sv
module entry_sequencer
    import ring_wr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DESC_W-1:0] in_desc,
    input  logic             room,
    output logic             in_ready,
    output logic             wr_en,
    output logic [CNT_W-1:0] wr_sel,
    output dword_t           wr_raw,
    output logic             last
);
    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [DESC_W-1:0] desc;
    } seq_state_t;

    seq_state_t st_d, st_q;
    dword_t     dw [ENTRY_DWORDS];

    for (genvar g = 0; g < ENTRY_DWORDS; g++) begin : g_split
        assign dw[g] = st_q.desc[g*DWORD_W +: DWORD_W];
    end

    always_comb begin
        in_ready = !st_q.busy && room;
        last     = st_q.busy && (st_q.cnt == CNT_W'(ENTRY_DWORDS - 1));

        st_d = st_q;
        if (st_q.busy) begin
            if (last) st_d.busy = 1'b0;
            else      st_d.cnt  = st_q.cnt + 1'b1;
        end else if (in_valid && in_ready) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.desc = in_desc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en  = st_q.busy;
    assign wr_sel = st_q.cnt;
    assign wr_raw = dw[st_q.cnt];
endmodule

// File: rtl/dword_stamp.sv
module dword_stamp
    import ring_wr_pkg::*;
(
    input  logic [CNT_W-1:0]  wr_sel,
    input  dword_t            raw,
    input  logic [ID_W-1:0]   ring_id,
    input  logic [LOOP_W-1:0] loop_val,
    output dword_t            data
);
    localparam logic [CNT_W-1:0] LAST_SEL = CNT_W'(ENTRY_DWORDS - 1);

    always_comb begin
        data = raw;
        if (wr_sel == LAST_SEL) begin
            data[LOOP_LSB +: LOOP_W] = loop_val;
            data[ID_LSB   +: ID_W]   = ring_id;
            data[RSV_LSB  +: RSV_W]  = '0;
        end
    end
endmodule

// File: rtl/desc_ring_writer.sv
module desc_ring_writer
    import ring_wr_pkg::*;
#(
    parameter  int ADDR_W   = 32,
    parameter  int MAX_LOG2 = 6,
    localparam int IDX_W    = MAX_LOG2,
    localparam int LG_W     = $clog2(MAX_LOG2 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DESC_W-1:0] in_desc,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LG_W-1:0]   cfg_log2_size,
    input  logic [ID_W-1:0]   cfg_ring_id,
    input  logic [IDX_W-1:0]  tail_idx,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DWORD_W-1:0] mem_wr_data,
    output logic [IDX_W-1:0]  head_idx,
    output logic              irq_pulse
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << SLOT_SHIFT) - 1);

    logic              full;
    logic              last;
    logic [CNT_W-1:0]  wr_sel;
    dword_t            wr_raw;
    logic [LOOP_W-1:0] stamp_loop;
    logic              irq_d, irq_q;

    ring_head_ctrl #(
        .MAX_LOG2 (MAX_LOG2),
        .IDX_W    (IDX_W),
        .LG_W     (LG_W)
    ) head_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_log2_size (cfg_log2_size),
        .tail_idx      (tail_idx),
        .advance       (last),
        .head_idx      (head_idx),
        .stamp_loop    (stamp_loop),
        .full          (full)
    );

    entry_sequencer seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_desc  (in_desc),
        .room     (!full),
        .in_ready (in_ready),
        .wr_en    (mem_wr_en),
        .wr_sel   (wr_sel),
        .wr_raw   (wr_raw),
        .last     (last)
    );

    dword_stamp stamp_i (
        .wr_sel   (wr_sel),
        .raw      (wr_raw),
        .ring_id  (cfg_ring_id),
        .loop_val (stamp_loop),
        .data     (mem_wr_data)
    );

    always_comb begin
        mem_wr_addr = (cfg_base & ALIGN_MASK)
                    + (ADDR_W'(head_idx) << SLOT_SHIFT)
                    + (ADDR_W'(wr_sel) << 2);
        irq_d = last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_pulse = irq_q;
endmodule

// File: rtl/desc_ring_writer_chk.sv
module desc_ring_writer_chk
    import ring_wr_pkg::*;
#(
    parameter  int ADDR_W   = 32,
    parameter  int MAX_LOG2 = 6,
    localparam int IDX_W    = MAX_LOG2,
    localparam int LG_W     = $clog2(MAX_LOG2 + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [LG_W-1:0]  cfg_log2_size,
    input logic [ID_W-1:0]  cfg_ring_id,
    input logic [IDX_W-1:0] tail_idx,
    input logic             mem_wr_en,
    input logic [CNT_W-1:0] wr_word_sel,
    input logic [11:0]      wr_stamp_bits,
    input logic [IDX_W-1:0] head_idx,
    input logic             irq_pulse
);
    logic [CNT_W:0]   run_q;
    logic [IDX_W-1:0] mask_c;
    logic             legal_c;
    logic             full_c;

    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= '0;
        else if (mem_wr_en) run_q <= run_q + 1'b1;
        else                run_q <= '0;
    end

    always_comb begin
        legal_c = (cfg_log2_size != '0) && (int'(cfg_log2_size) <= MAX_LOG2);
        for (int i = 0; i < IDX_W; i++)
            mask_c[i] = (i < int'(cfg_log2_size));
        full_c = legal_c && (((head_idx + 1'b1) & mask_c) == (tail_idx & mask_c));
    end

    // R2: a burst never exceeds one entry and words leave in order
    p_burst_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (run_q < (CNT_W+1)'(ENTRY_DWORDS)));
    p_burst_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (wr_word_sel == run_q[CNT_W-1:0]));
    p_start_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_en) |-> $past(in_valid && in_ready));
    // R4: stamp id and reserved nibble in the final word
    p_stamp_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && wr_word_sel == CNT_W'(ENTRY_DWORDS - 1))
        |-> (wr_stamp_bits[3:0] == 4'h0 && wr_stamp_bits[11:4] == cfg_ring_id));
    // R6: interrupt is one cycle, follows the eighth word, and the head moves only then
    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);
    p_irq_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ($past(mem_wr_en) && $past(run_q) == (CNT_W+1)'(ENTRY_DWORDS - 1)));
    p_head_on_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (head_idx != $past(head_idx)) |-> irq_pulse);
    // R7: no acceptance during a burst
    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !in_ready);
    // R8: full ring back-pressures
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full_c |-> !in_ready);
endmodule

bind desc_ring_writer desc_ring_writer_chk #(
    .ADDR_W   (ADDR_W),
    .MAX_LOG2 (MAX_LOG2)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .cfg_log2_size (cfg_log2_size),
    .cfg_ring_id   (cfg_ring_id),
    .tail_idx      (tail_idx),
    .mem_wr_en     (mem_wr_en),
    .wr_word_sel   (mem_wr_addr[4:2]),
    .wr_stamp_bits (mem_wr_data[27:16]),
    .head_idx      (head_idx),
    .irq_pulse     (irq_pulse)
);

// File: tb/desc_ring_writer_tb_top.sv
`timescale 1ns/1ps
module desc_ring_writer_tb_top;
    localparam int ADDR_W = 32;
    localparam int MAXL   = 6;
    localparam logic [31:0] BASE = 32'h0000_4000;

    // {seed, low16 of word 7, expected slot, expected pass value}
    localparam logic [63:0] VEC [8] = '{
        {32'h0000_0000, 16'h0000, 8'd0, 8'd1},
        {32'hFFFF_FFFF, 16'hFFFF, 8'd1, 8'd1},
        {32'hA5A5_A5A5, 16'h1234, 8'd2, 8'd1},
        {32'h5A5A_5A5A, 16'hBEEF, 8'd3, 8'd1},
        {32'h8000_0001, 16'h0001, 8'd0, 8'd2},
        {32'h1234_5678, 16'h8000, 8'd1, 8'd2},
        {32'hDEAD_BEEF, 16'h00FF, 8'd2, 8'd2},
        {32'h0F0F_0F0F, 16'hF00D, 8'd3, 8'd2}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [255:0]      in_desc = '0;
    logic [ADDR_W-1:0] cfg_base = BASE;
    logic [2:0]        cfg_log2_size = 3'd2;
    logic [7:0]        cfg_ring_id = 8'hA5;
    logic [MAXL-1:0]   tail_idx = '0;
    logic              mem_wr_en;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [31:0]       mem_wr_data;
    logic [MAXL-1:0]   head_idx;
    logic              irq_pulse;

    int          n_checks = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [31:0] mem [0:511];
    int          wlog [0:1023];
    int          wcnt = 0;

    always #4 clk = ~clk;

    desc_ring_writer #(.ADDR_W(ADDR_W), .MAX_LOG2(MAXL)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_desc(in_desc), .cfg_base(cfg_base), .cfg_log2_size(cfg_log2_size),
        .cfg_ring_id(cfg_ring_id), .tail_idx(tail_idx), .mem_wr_en(mem_wr_en),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .head_idx(head_idx), .irq_pulse(irq_pulse)
    );

    // memory model: outputs are stable mid-cycle, captured at the falling edge
    always @(negedge clk) begin
        if (mem_wr_en) begin
            int widx;
            widx = int'((mem_wr_addr - BASE) >> 2);
            if (widx >= 0 && widx < 512) mem[widx] = mem_wr_data;
            if (wcnt < 1024) wlog[wcnt] = widx;
            wcnt = wcnt + 1;
        end
    end

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [31:0] seed, input int k);
        return seed ^ (32'h0101_0101 * k);
    endfunction

    task automatic push_entry(input logic [31:0] seed, input logic [15:0] low16,
                              input int slot, input int loopv, input int size);
        int snap;
        int t;
        logic [31:0] w7;
        t = 0;
        while (!in_ready && t < 50) begin
            @(negedge clk);
            t++;
        end
        check_eq("R8 ready with room", {31'd0, in_ready}, 32'd1);
        snap = wcnt;
        for (int k = 0; k < 7; k++) in_desc[k*32 +: 32] = word_of(seed, k);
        in_desc[255:224] = {16'hFFFF, low16};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_eq("R7 not ready while writing", {31'd0, in_ready}, 32'd0);
        repeat (7) @(negedge clk);
        check_eq("R6 head held through last word", 32'(head_idx), 32'(slot));
        check_eq("R6 no early interrupt", {31'd0, irq_pulse}, 32'd0);
        @(negedge clk);
        check_eq("R6 interrupt after entry", {31'd0, irq_pulse}, 32'd1);
        check_eq("R9 head advance modulo size", 32'(head_idx), 32'((slot + 1) % size));
        @(negedge clk);
        check_eq("R6 interrupt one cycle", {31'd0, irq_pulse}, 32'd0);
        check_eq("R2 eight writes", 32'(wcnt - snap), 32'd8);
        for (int k = 0; k < 8; k++)
            check_eq("R2 word order and address", 32'(wlog[snap + k]), 32'(slot * 8 + k));
        for (int k = 0; k < 7; k++)
            check_eq("R3 word copied", mem[slot * 8 + k], word_of(seed, k));
        w7 = mem[slot * 8 + 7];
        check_eq("R3 low half of word 7", {16'd0, w7[15:0]}, {16'd0, low16});
        check_eq("R4 ring id", {24'd0, w7[27:20]}, {24'd0, cfg_ring_id});
        check_eq("R4 reserved zero", {28'd0, w7[19:16]}, 32'd0);
        check_eq("R5 pass value", {28'd0, w7[31:28]}, 32'(loopv % 16));
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic prev_lsb [2];
        int   wc_snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 head after reset", 32'(head_idx), 32'd0);
        check_eq("R1 irq after reset", {31'd0, irq_pulse}, 32'd0);
        check_eq("R1 no write after reset", {31'd0, mem_wr_en}, 32'd0);
        check_eq("R1 ready after reset", {31'd0, in_ready}, 32'd1);

        // table walk: four-slot ring, consumer keeps pace
        for (int v = 0; v < 8; v++) begin
            tail_idx = MAXL'(VEC[v][15:8]);
            push_entry(VEC[v][63:32], VEC[v][31:16], int'(VEC[v][15:8]),
                       int'(VEC[v][7:0]), 4);
        end

        // R8: consumer stalls at slot 0
        tail_idx = '0;
        push_entry(32'h1111_2222, 16'hAAAA, 0, 3, 4);
        push_entry(32'h3333_4444, 16'h5555, 1, 3, 4);
        push_entry(32'h6666_7777, 16'hC0DE, 2, 3, 4);
        check_eq("R8 not ready when full", {31'd0, in_ready}, 32'd0);
        wc_snap = wcnt;
        for (int k = 0; k < 8; k++) in_desc[k*32 +: 32] = 32'hBAD0_0000 + k;
        in_valid = 1'b1;
        repeat (5) @(negedge clk);
        in_valid = 1'b0;
        check_eq("R8 no write while full", 32'(wcnt - wc_snap), 32'd0);
        check_eq("R8 head frozen while full", 32'(head_idx), 32'd3);
        tail_idx = MAXL'(1);
        #1;
        check_eq("R8 ready after tail moves", {31'd0, in_ready}, 32'd1);
        push_entry(32'h9999_AAAA, 16'h7777, 3, 3, 4);
        check_eq("R8 full again after wrap", {31'd0, in_ready}, 32'd0);

        // R1 again after a mid-run reset, then two-slot ring across 16 passes
        @(negedge clk);
        rst_n = 1'b0;
        cfg_log2_size = 3'd1;
        cfg_ring_id = 8'h3C;
        tail_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 head after second reset", 32'(head_idx), 32'd0);
        check_eq("R1 ready after second reset", {31'd0, in_ready}, 32'd1);
        for (int k = 0; k < 32; k++) begin
            int slot;
            logic lsb;
            slot = k % 2;
            tail_idx = MAXL'(slot);
            push_entry(32'hC000_0000 + 32'(k), 16'(k * 3), slot, k / 2 + 1, 2);
            lsb = mem[slot * 8 + 7][28];
            if (k >= 2)
                check_eq("R10 pass bit alternates", {31'd0, lsb}, {31'd0, ~prev_lsb[slot]});
            prev_lsb[slot] = lsb;
        end
        check_eq("R5 rollover to zero", {28'd0, mem[7][31:28]}, 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule